// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming frame, whether the frame is kept, using only its 48-bit destination address. The address arrives with a one-cycle valid strobe. Two clock cycles later a registered decision comes out. A frame is kept in three cases. The first is that the promiscuous control bit is set. The second is that the address equals one of several exact-match entries whose enable bit is set. The third is that the address is a group (multicast) address, hashing is enabled, and the bin that the address hashes to is set in a 64-bin table.

Software programs the block through a simple 16-bit register port. Writes take effect on the clock edge, and reads are combinational from the selected address. Each stored 48-bit address is held as three 16-bit words in reversed byte order. After reset, entry 0 already holds the all-ones address and is enabled, so broadcast traffic is kept. Entry 1 is meant for the station's own address. Exact-match entries are protected against torn updates: the words of an entry can only be rewritten while that entry is disabled.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the control word (address 0) reads 0x0100, the four hash words (addresses 1 to 4) read 0, the three words of entry 0 (addresses 8, 9, 10) read 0xFFFF, the words of every other entry read 0, and dec_vld is low.
- R2: A cycle with addr_vld high produces exactly one cycle of dec_vld two clock cycles later, with that address's decision on dec_accept. Back-to-back strobes give back-to-back decisions in order, and dec_vld is low otherwise.
- R3: When control bit 0 (promiscuous) is set, every address is accepted.
- R4: Entry e occupies addresses 8+3e (low word), 9+3e (mid word) and 10+3e (high word). The first address byte on the wire is byte0 (dest_addr[47:40]) and the last is byte5 (dest_addr[7:0]). The low word holds byte1:byte0, the mid word byte3:byte2 and the high word byte5:byte4, with the odd byte in bits 15:8. An address equal to an enabled entry is accepted.
- R5: Control bit 8+e enables entry e. While that bit is clear, entry e never matches.
- R6: A write to any word of an entry whose enable bit is set is ignored. The word keeps its value, as seen on readback.
- R7: The hash bin comes from a CRC register set to all ones. The six address bytes are fed in wire order, each byte least significant bit first. For each bit, the register shifts left, and it is XORed with 0x04C11DB7 when the old bit 31 differs from the data bit. There is no final inversion. The bin is bits 28:23 of the result. Bin bits 5:4 select hash word 1 to 4 (at address 1 plus that value), and bin bits 3:0 select the bit within that word.
- R8: The hash check applies only when dest_addr[40] (the group bit) is 1 and control bit 1 (hash enable) is set. An address with the group bit clear is never accepted through the hash.
- R9: With all four hash words at 0xFFFF and hashing enabled, every group address is accepted. With hashing disabled, the same addresses are rejected unless some other rule accepts them.
- R10: Directly after reset, the broadcast address is accepted and any other address is rejected.
- R11: Reads from addresses outside the map (5 to 7, and above the last entry) return 0. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | Destination address valid strobe |
| dest_addr | input | 48 | Destination address, first wire byte in bits 47:40 |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address for read and write |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |
| dec_vld | output | 1 | Decision valid, two cycles after addr_vld |
| dec_accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
Each kind of internal fault shows up at the ports within the two-cycle decision window of the first address that exercises it:
- A wrong CRC bit or swapped table index accepts a group address whose bin is clear, or drops one whose bin is set.
- A wrong byte order in the comparator drops the station's own address.
- A broken lock on enabled entries shows up one write later as a changed readback word.
- A broken pipeline valid shows up as dec_vld high in the wrong cycle.

The addresses used include the station address, a one-byte near miss of it, broadcast, several group addresses and locally administered unicast. They are run under more than one control setting, so every accept path is tested both on its own and switched off.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int unsigned MAC_W     = 48;
  localparam int unsigned OCTETS    = MAC_W / 8;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned WORDS_PER = MAC_W / REG_W;
  localparam int unsigned BIN_W     = 6;
  localparam int unsigned BIN_LSB   = 23;
  localparam int unsigned BINS      = 1 << BIN_W;
  localparam int unsigned HASH_WRDS = BINS / REG_W;
  localparam int unsigned CTRL_ADR  = 0;
  localparam int unsigned HASH_ADR  = 1;
  localparam int unsigned ENT_ADR   = 8;
  localparam int unsigned EN_LSB    = 8;
  localparam logic [31:0] CRC_GEN   = 32'h04C1_1DB7;

  typedef logic [MAC_W-1:0] mac_t;
  typedef logic [BIN_W-1:0] bin_t;

  // Serial-equivalent CRC over the address bytes, wire order, LSB of each byte first
  function automatic bin_t addr_hash_bin(input mac_t da);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int o = 0; o < OCTETS; o++) begin
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ da[MAC_W - 8 - 8*o + k];
        c  = {c[30:0], 1'b0} ^ (fb ? CRC_GEN : 32'h0);
      end
    end
    return c[BIN_LSB +: BIN_W];
  endfunction
endpackage

// File: rtl/af_hash_bin.sv
module af_hash_bin
  import af_pkg::*;
(
  input  mac_t dest,
  output bin_t bin,
  output logic is_group
);
  assign bin      = addr_hash_bin(dest);
  // group bit is the least significant bit of the first wire byte
  assign is_group = dest[MAC_W-8];
endmodule

// File: rtl/af_exact_cmp.sv
module af_exact_cmp
  import af_pkg::*;
#(
  parameter int unsigned N_ENT = 4
) (
  input  mac_t                  dest,
  input  logic [N_ENT-1:0][MAC_W-1:0] ent_addr,
  input  logic [N_ENT-1:0]      ent_en,
  output logic [N_ENT-1:0]      hit
);
  mac_t key;

  // stored form is byte5..byte0 from high to low, so reverse the wire bytes
  for (genvar g = 0; g < OCTETS; g++) begin : g_swap
    assign key[8*g +: 8] = dest[MAC_W-8-8*g +: 8];
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign hit[e] = ent_en[e] && (ent_addr[e] == key);
  end
endmodule

// File: rtl/af_regs.sv
module af_regs
  import af_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned AW    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            rdata,
  output logic                        promisc,
  output logic                        hash_en,
  output logic [N_ENT-1:0]            ent_en,
  output logic [N_ENT-1:0][MAC_W-1:0] ent_addr,
  output logic [BINS-1:0]             hash_tbl
);
  localparam logic [N_ENT-1:0] EN_RST = N_ENT'(1);
  localparam logic [N_ENT-1:0][MAC_W-1:0] ENT_RST =
    {{((N_ENT-1)*MAC_W){1'b0}}, {MAC_W{1'b1}}};

  logic                        promisc_q, promisc_d;
  logic                        hash_en_q, hash_en_d;
  logic [N_ENT-1:0]            en_q, en_d;
  logic [N_ENT-1:0][MAC_W-1:0] ent_q, ent_d;
  logic [BINS-1:0]             hash_q, hash_d;

  // next state
  always_comb begin
    promisc_d = promisc_q;
    hash_en_d = hash_en_q;
    en_d      = en_q;
    ent_d     = ent_q;
    hash_d    = hash_q;
    if (addr == AW'(CTRL_ADR)) begin
      promisc_d = wdata[0];
      hash_en_d = wdata[1];
      en_d      = wdata[EN_LSB +: N_ENT];
    end
    for (int h = 0; h < HASH_WRDS; h++) begin
      if (addr == AW'(HASH_ADR + h)) hash_d[h*REG_W +: REG_W] = wdata;
    end
    for (int e = 0; e < N_ENT; e++) begin
      for (int w = 0; w < WORDS_PER; w++) begin
        if (addr == AW'(ENT_ADR + WORDS_PER*e + w) && !en_q[e])
          ent_d[e][w*REG_W +: REG_W] = wdata;
      end
    end
  end

  // state registers with write enable as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promisc_q <= 1'b0;
      hash_en_q <= 1'b0;
      en_q      <= EN_RST;
      ent_q     <= ENT_RST;
      hash_q    <= '0;
    end else if (we) begin
      promisc_q <= promisc_d;
      hash_en_q <= hash_en_d;
      en_q      <= en_d;
      ent_q     <= ent_d;
      hash_q    <= hash_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == AW'(CTRL_ADR)) begin
      rdata[0] = promisc_q;
      rdata[1] = hash_en_q;
      rdata[EN_LSB +: N_ENT] = en_q;
    end
    for (int h = 0; h < HASH_WRDS; h++) begin
      if (addr == AW'(HASH_ADR + h)) rdata = hash_q[h*REG_W +: REG_W];
    end
    for (int e = 0; e < N_ENT; e++) begin
      for (int w = 0; w < WORDS_PER; w++) begin
        if (addr == AW'(ENT_ADR + WORDS_PER*e + w)) rdata = ent_q[e][w*REG_W +: REG_W];
      end
    end
  end

  assign promisc  = promisc_q;
  assign hash_en  = hash_en_q;
  assign ent_en   = en_q;
  assign ent_addr = ent_q;
  assign hash_tbl = hash_q;

  for (genvar e = 0; e < N_ENT; e++) begin : g_lock
    for (genvar w = 0; w < WORDS_PER; w++) begin : g_word
      AST_LOCKED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(ENT_ADR + WORDS_PER*e + w) && en_q[e])
          |=> $stable(ent_q[e][w*REG_W +: REG_W])); // R6
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import af_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned AW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [47:0]       dest_addr,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  output logic              dec_vld,
  output logic              dec_accept
);
  logic                        promisc, hash_en;
  logic [N_ENT-1:0]            ent_en;
  logic [N_ENT-1:0][MAC_W-1:0] ent_addr;
  logic [BINS-1:0]             hash_tbl;
  logic [N_ENT-1:0]            hit_c;
  bin_t                        bin_c;
  logic                        grp_c;

  af_regs #(.N_ENT(N_ENT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .promisc(promisc), .hash_en(hash_en), .ent_en(ent_en),
    .ent_addr(ent_addr), .hash_tbl(hash_tbl)
  );

  af_exact_cmp #(.N_ENT(N_ENT)) u_cmp (
    .dest(dest_addr), .ent_addr(ent_addr), .ent_en(ent_en), .hit(hit_c)
  );

  af_hash_bin u_hash (.dest(dest_addr), .bin(bin_c), .is_group(grp_c));

  // stage 1: match vector, hash bin, group bit
  logic             s1_vld;
  logic [N_ENT-1:0] s1_hit;
  bin_t             s1_bin;
  logic             s1_grp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_hit <= '0;
      s1_bin <= '0;
      s1_grp <= 1'b0;
    end else begin
      s1_vld <= addr_vld;
      if (addr_vld) begin
        s1_hit <= hit_c;
        s1_bin <= bin_c;
        s1_grp <= grp_c;
      end
    end
  end

  // stage 2: combine
  logic acc_d;
  always_comb begin
    acc_d = s1_vld && (promisc || (|s1_hit) || (s1_grp && hash_en && hash_tbl[s1_bin]));
  end

  logic dec_vld_q, dec_acc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld_q <= 1'b0;
      dec_acc_q <= 1'b0;
    end else begin
      dec_vld_q <= s1_vld;
      dec_acc_q <= acc_d;
    end
  end

  assign dec_vld    = dec_vld_q;
  assign dec_accept = dec_acc_q;

  AST_DECISION_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> ##1 dec_vld); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !dec_vld); // R2
  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && promisc) |=> dec_accept); // R3
  AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_grp && !(|s1_hit) && !promisc) |=> !dec_accept); // R8

  for (genvar e = 0; e < N_ENT; e++) begin : g_dis
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && !ent_en[e]) |=> !s1_hit[e]); // R5
  end
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_vld;
  logic [47:0] dest_addr;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        dec_vld, dec_accept;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .dest_addr(dest_addr),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dec_vld(dec_vld), .dec_accept(dec_accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // model of programmed state, built from the requirements
  logic          m_prom, m_hen;
  logic [NE-1:0] m_en;
  logic [47:0]   m_ent [NE];
  logic [63:0]   m_hash;

  localparam logic [47:0] STATION = 48'h0007_4300_1309;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    48'h0007_4300_1309, 48'hFFFF_FFFF_FFFF, 48'h0007_4300_1308, 48'h0100_5E00_0001,
    48'h0100_5E7F_0203, 48'h3333_0000_0001, 48'h0180_C200_0000, 48'h0200_0000_0001,
    48'h0000_0000_0000, 48'h0907_4313_00FF
  };

  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic msb = c[31];
        c = c << 1;
        if (msb ^ b[j]) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[28:23];
  endfunction

  function automatic logic [47:0] stored_form(input logic [47:0] a);
    return {a[7:0], a[15:8], a[23:16], a[31:24], a[39:32], a[47:40]};
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic hit = 1'b0;
    for (int e = 0; e < NE; e++) if (m_en[e] && m_ent[e] == stored_form(a)) hit = 1'b1;
    return m_prom || hit || (a[40] && m_hen && m_hash[ref_bin(a)]);
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) begin
      m_prom = d[0]; m_hen = d[1]; m_en = d[8 +: NE];
    end else if (a >= 1 && a <= 4) begin
      m_hash[(a-1)*16 +: 16] = d;
    end else if (a >= 8 && a < 8 + 3*NE) begin
      int e = (a - 8) / 3;
      int w = (a - 8) % 3;
      if (!m_en[e]) m_ent[e][w*16 +: 16] = d;
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send(input logic [47:0] a, input string req);
    @(negedge clk);
    addr_vld = 1'b1; dest_addr = a;
    @(posedge clk);
    @(negedge clk);
    addr_vld = 1'b0;
    chk({req, " vld early"}, {47'b0, dec_vld}, 48'd0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " vld"}, {47'b0, dec_vld}, 48'd1);
    chk({req, " accept"}, {47'b0, dec_accept}, {47'b0, ref_accept(a)});
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    logic [5:0]  b;
    rst_n = 1'b0; addr_vld = 1'b0; dest_addr = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    m_prom = 0; m_hen = 0; m_en = 4'b0001; m_hash = '0;
    for (int e = 0; e < NE; e++) m_ent[e] = (e == 0) ? '1 : '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 dec_vld", {47'b0, dec_vld}, 48'd0);
    rd(0, d); chk("R1 ctrl", {32'b0, d}, 48'h0100);
    for (int h = 1; h <= 4; h++) begin rd(5'(h), d); chk("R1 hash word", {32'b0, d}, 48'h0); end
    for (int w = 8; w <= 10; w++) begin rd(5'(w), d); chk("R1 entry0 word", {32'b0, d}, 48'hFFFF); end
    rd(11, d); chk("R1 entry1 low", {32'b0, d}, 48'h0);

    // R10 broadcast only after reset
    send(BCAST, "R10 broadcast");
    send(STATION, "R10 unicast");
    send(48'h0100_5E00_0001, "R10 group");

    // R4 program station into entry 1 (byte-swapped words), then enable it
    wr(11, 16'h0700); wr(12, 16'h0043); wr(13, 16'h0913);
    rd(11, d); chk("R4 low word", {32'b0, d}, 48'h0700);
    wr(0, 16'h0300);
    send(STATION, "R4 station");
    send(48'h0007_4300_1308, "R4 near miss");

    // R7 single bin set, check word selection and bit position
    b = ref_bin(48'h0100_5E00_0001);
    wr(5'(1 + b[5:4]), 16'(1) << b[3:0]);
    wr(0, 16'h0302);
    rd(5'(1 + b[5:4]), d); chk("R7 bin word", {32'b0, d}, {32'b0, 16'(1) << b[3:0]});
    send(48'h0100_5E00_0001, "R7 bin hit");

    // table walk under this configuration (R4 R7 R8 R10)
    for (int i = 0; i < NV; i++) send(VEC[i], "R8 table");

    // R7 move the bit to a neighbouring bin: the same address must drop
    wr(5'(1 + b[5:4]), 16'h0000);
    wr(5'(1 + ((b ^ 6'd1) >> 4)), 16'(1) << ((b ^ 6'd1) & 6'hF));
    send(48'h0100_5E00_0001, "R7 neighbour bin");

    // R2 back-to-back strobes
    @(negedge clk); addr_vld = 1'b1; dest_addr = STATION;
    @(posedge clk);
    @(negedge clk); dest_addr = 48'h0200_0000_0001;
    @(posedge clk);
    @(negedge clk); addr_vld = 1'b0;
    chk("R2 first vld", {47'b0, dec_vld}, 48'd1);
    chk("R2 first accept", {47'b0, dec_accept}, 48'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R2 second vld", {47'b0, dec_vld}, 48'd1);
    chk("R2 second accept", {47'b0, dec_accept}, 48'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 idle", {47'b0, dec_vld}, 48'd0);

    // R6 locked entry write ignored, unlocked write lands
    wr(11, 16'h1234);
    rd(11, d); chk("R6 locked", {32'b0, d}, 48'h0700);
    send(STATION, "R6 still matches");

    // R5 disabled entry never matches
    wr(0, 16'h0102);
    send(STATION, "R5 disabled");
    wr(11, 16'h1234);
    rd(11, d); chk("R6 unlocked write", {32'b0, d}, 48'h1234);
    wr(11, 16'h0700);

    // R9 all-ones hash accepts all group addresses; off when hashing disabled
    for (int h = 1; h <= 4; h++) wr(5'(h), 16'hFFFF);
    send(48'h0100_5E7F_0203, "R9 all group");
    send(48'h3333_0000_0001, "R9 all group");
    send(48'h0200_0000_0001, "R8 unicast vs full table");
    wr(0, 16'h0100);
    send(48'h3333_0000_0001, "R9 hash off");

    // R3 promiscuous
    wr(0, 16'h0101);
    send(48'h0200_0000_0001, "R3 promisc unicast");
    send(48'h0007_4300_1308, "R3 promisc near miss");
    wr(0, 16'h0100);

    // R11 unmapped addresses
    wr(6, 16'hBEEF);
    rd(6, d); chk("R11 unmapped read", {32'b0, d}, 48'h0);
    rd(31, d); chk("R11 top read", {32'b0, d}, 48'h0);
    rd(0, d); chk("R11 ctrl intact", {32'b0, d}, 48'h0100);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule